// File: doc/BRIEF.md
# Block-Transfer Micro-op Sequencer

This block takes one multi-register load or store request and turns it into a stream of simple micro-op descriptors. It emits one descriptor per cycle on a valid/ready handshake. A request carries a 16-bit register select mask, a base register index and five flags: ascending direction, pre-step, base update, load versus store, and user-bank access. The sequencer only builds descriptors. Executing them, the memory access and the banked register lookup happen downstream.

Every sequence opens with a copy of the base register into a hidden scratch register (index 16). All transfers then address memory relative to that scratch copy, so a base register that also appears in the mask cannot disturb the addresses. For a descending transfer, the first offset comes from the population count of the mask, so the transfers still run from the lowest register upward. An optional base-update micro-op closes the sequence. The final descriptor is marked as last.

Top module: `lsm_uop_seq`

## Requirements
- R1: The first descriptor of every sequence is kind 0 (add-immediate) with dst 16 (scratch), src equal to the base index and imm 0.
- R2: Each set bit of the mask produces one transfer descriptor, in ascending register order, with dst equal to the register index and src 16.
- R3: With N set bits, the first transfer offset is 0 when ascending and 4N-4 when descending. When the pre-step flag is set, 4 is added to it.
- R4: Each later transfer offset is 4 above the previous one when ascending and 4 below it when descending. `uop_neg_o` is 1 (subtract the offset) exactly when descending.
- R5: The transfer kind is 2 for a load and 3 for a store. A load of register 15 with the user-bank flag set has kind 4 (load with status restore) and `uop_psr_mask_o` = 4'hF. Every other descriptor has mask 0.
- R6: `uop_user_o` equals the user-bank flag on transfer descriptors and is 0 on the copy and base-update descriptors.
- R7: When the base-update flag is set, the final descriptor has dst = src = base and imm = 4N. Its kind is 0 when ascending and 1 (subtract-immediate) when descending.
- R8: Exactly N+1 descriptors are emitted, or N+2 with base update. Only the final one has `uop_last_o` set.
- R9: An empty mask yields only the copy descriptor, followed by the base-update descriptor when that flag is set.
- R10: While `uop_valid_o` is high and `uop_ready_i` is low, all descriptor outputs hold their values.
- R11: `req_ready_o` is high only when no sequence is in progress. A request presented during a sequence is ignored, and a new one is taken in the cycle after the last descriptor is consumed.
- R12: While reset is asserted and right after it, `uop_valid_o` is 0 and `req_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Sequencer idle and able to take a request |
| reg_list_i | input | 16 | Register select mask |
| base_idx_i | input | 4 | Base register index |
| up_i | input | 1 | Ascending addresses |
| pre_i | input | 1 | Step before the first access |
| wb_i | input | 1 | Update the base register at the end |
| load_i | input | 1 | 1 = load, 0 = store |
| user_i | input | 1 | Access user-bank registers |
| uop_valid_o | output | 1 | Descriptor valid |
| uop_ready_i | input | 1 | Downstream takes the descriptor |
| uop_kind_o | output | 3 | 0 add-imm, 1 sub-imm, 2 load, 3 store, 4 load with status restore |
| uop_dst_o | output | 5 | Destination or data register (16 = scratch) |
| uop_src_o | output | 5 | Source or address register |
| uop_imm_o | output | 8 | Immediate offset |
| uop_neg_o | output | 1 | Address is src minus imm |
| uop_user_o | output | 1 | Register index needs user-bank remapping |
| uop_psr_mask_o | output | 4 | Status field write mask |
| uop_last_o | output | 1 | Final descriptor of the sequence |

## Verification
Some properties are checked on every cycle: descriptors hold under backpressure, `req_ready_o` is low while busy, and every sequence opens with the scratch copy. Transfers always address through the scratch register, and successive offsets step by exactly 4 in the flagged direction with rising register indices. The status-restore kind appears only for register 15 under the user-bank flag. Other behaviour can only be shown by the bench's scenarios, which compare each emitted stream against a model of the expected one. These cover the starting offset from the population count, the exact descriptor count, the base-update immediate and kind, and correct placement of the last flag, including empty masks and a full mask.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [2:0] {
    K_ADDI     = 3'd0,
    K_SUBI     = 3'd1,
    K_LOAD     = 3'd2,
    K_STORE    = 3'd3,
    K_LOAD_RET = 3'd4
  } uop_kind_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_COPY,
    S_XFER,
    S_WB
  } seq_state_e;
endpackage

// File: rtl/lsm_popcount.sv
module lsm_popcount #(
  parameter int N  = 16,
  parameter int CW = $clog2(N) + 1
) (
  input  logic [N-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < N; i++) cnt_o = cnt_o + CW'(vec_i[i]);
  end
endmodule

// File: rtl/lsm_lsb_pick.sv
module lsm_lsb_pick #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  onehot_o,
  output logic          multi_o
);
  assign onehot_o = vec_i & (~vec_i + N'(1));
  assign multi_o  = |(vec_i & (vec_i - N'(1)));

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) if (vec_i[i]) idx_o = IW'(i);
  end
endmodule

// File: rtl/lsm_uop_seq.sv
module lsm_uop_seq
  import lsm_pkg::*;
#(
  parameter int NREGS      = 16,
  parameter int WORD_BYTES = 4,
  parameter int REG_W      = $clog2(NREGS),
  parameter int UREG_W     = REG_W + 1,
  parameter int OFS_W      = $clog2(NREGS * WORD_BYTES + WORD_BYTES) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [NREGS-1:0]  reg_list_i,
  input  logic [REG_W-1:0]  base_idx_i,
  input  logic              up_i,
  input  logic              pre_i,
  input  logic              wb_i,
  input  logic              load_i,
  input  logic              user_i,
  output logic              uop_valid_o,
  input  logic              uop_ready_i,
  output logic [2:0]        uop_kind_o,
  output logic [UREG_W-1:0] uop_dst_o,
  output logic [UREG_W-1:0] uop_src_o,
  output logic [OFS_W-1:0]  uop_imm_o,
  output logic              uop_neg_o,
  output logic              uop_user_o,
  output logic [3:0]        uop_psr_mask_o,
  output logic              uop_last_o
);
  localparam int CW = $clog2(NREGS) + 1;
  localparam logic [OFS_W-1:0]  STEP    = OFS_W'(WORD_BYTES);
  localparam logic [UREG_W-1:0] TMP_REG = UREG_W'(NREGS);
  localparam logic [REG_W-1:0]  PC_REG  = REG_W'(NREGS - 1);

  seq_state_e        state_q, state_d;
  logic [NREGS-1:0]  list_q;
  logic [REG_W-1:0]  base_q;
  logic              up_q, wb_q, ld_q, usr_q;
  logic [OFS_W-1:0]  ofs_q, span_q;

  logic [CW-1:0]     cnt_d;
  logic [OFS_W-1:0]  span_d, ofs_start;
  logic [REG_W-1:0]  pick_idx;
  logic [NREGS-1:0]  pick_oh;
  logic              pick_multi;
  logic              fire, accept, is_ret;

  lsm_popcount #(.N(NREGS), .CW(CW)) u_cnt (
    .vec_i(reg_list_i),
    .cnt_o(cnt_d)
  );

  lsm_lsb_pick #(.N(NREGS), .IW(REG_W)) u_pick (
    .vec_i   (list_q),
    .idx_o   (pick_idx),
    .onehot_o(pick_oh),
    .multi_o (pick_multi)
  );

  assign span_d    = OFS_W'(cnt_d) * STEP;
  // descending start is precomputed so the walk still goes lowest register first
  assign ofs_start = (up_i ? '0 : span_d - STEP) + (pre_i ? STEP : '0);

  assign req_ready_o = (state_q == S_IDLE);
  assign uop_valid_o = (state_q != S_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign fire        = uop_valid_o && uop_ready_i;
  assign is_ret      = ld_q && usr_q && (pick_idx == PC_REG);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (accept) state_d = S_COPY;
      S_COPY: if (fire) state_d = (|list_q) ? S_XFER : (wb_q ? S_WB : S_IDLE);
      S_XFER: if (fire && !pick_multi) state_d = wb_q ? S_WB : S_IDLE;
      S_WB:   if (fire) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      list_q  <= '0;
      base_q  <= '0;
      up_q    <= 1'b0;
      wb_q    <= 1'b0;
      ld_q    <= 1'b0;
      usr_q   <= 1'b0;
      ofs_q   <= '0;
      span_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        list_q <= reg_list_i;
        base_q <= base_idx_i;
        up_q   <= up_i;
        wb_q   <= wb_i;
        ld_q   <= load_i;
        usr_q  <= user_i;
        ofs_q  <= ofs_start;
        span_q <= span_d;
      end else if (fire && state_q == S_XFER) begin
        list_q <= list_q & ~pick_oh;
        ofs_q  <= up_q ? ofs_q + STEP : ofs_q - STEP;
      end
    end
  end

  always_comb begin
    uop_kind_o     = K_ADDI;
    uop_dst_o      = TMP_REG;
    uop_src_o      = UREG_W'(base_q);
    uop_imm_o      = '0;
    uop_neg_o      = 1'b0;
    uop_user_o     = 1'b0;
    uop_psr_mask_o = 4'h0;
    uop_last_o     = 1'b0;
    unique case (state_q)
      S_COPY: uop_last_o = ~(|list_q) && !wb_q;
      S_XFER: begin
        uop_kind_o     = !ld_q ? K_STORE : (is_ret ? K_LOAD_RET : K_LOAD);
        uop_dst_o      = UREG_W'(pick_idx);
        uop_src_o      = TMP_REG;
        uop_imm_o      = ofs_q;
        uop_neg_o      = !up_q;
        uop_user_o     = usr_q;
        uop_psr_mask_o = is_ret ? 4'hF : 4'h0;
        uop_last_o     = !pick_multi && !wb_q;
      end
      S_WB: begin
        uop_kind_o = up_q ? K_ADDI : K_SUBI;
        uop_dst_o  = UREG_W'(base_q);
        uop_imm_o  = span_q;
        uop_last_o = 1'b1;
      end
      default: ;
    endcase
  end

  // checker state: previous accepted transfer
  logic             chk_xfer_q;
  logic [OFS_W-1:0] chk_imm_q;
  logic [UREG_W-1:0] chk_dst_q;
  logic             is_xfer_kind;

  assign is_xfer_kind = (uop_kind_o == K_LOAD) || (uop_kind_o == K_STORE) ||
                        (uop_kind_o == K_LOAD_RET);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_xfer_q <= 1'b0;
      chk_imm_q  <= '0;
      chk_dst_q  <= '0;
    end else begin
      chk_xfer_q <= fire && uop_valid_o && is_xfer_kind && !uop_last_o;
      if (fire) begin
        chk_imm_q <= uop_imm_o;
        chk_dst_q <= uop_dst_o;
      end
    end
  end

  p_copy_first_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(uop_valid_o) |-> (uop_kind_o == K_ADDI && uop_dst_o == TMP_REG && uop_imm_o == '0));

  p_src_tmp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uop_valid_o && is_xfer_kind) |-> (uop_src_o == TMP_REG));

  p_rising_dst_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_xfer_q && uop_valid_o && is_xfer_kind) |-> (uop_dst_o > chk_dst_q));

  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_xfer_q && uop_valid_o && is_xfer_kind) |->
      (uop_imm_o == (uop_neg_o ? chk_imm_q - STEP : chk_imm_q + STEP)));

  p_ret_pc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uop_valid_o && uop_kind_o == K_LOAD_RET) |->
      (uop_dst_o == UREG_W'(PC_REG) && uop_user_o && uop_psr_mask_o == 4'hF));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uop_valid_o && !uop_ready_i) |=>
      (uop_valid_o && $stable(uop_kind_o) && $stable(uop_dst_o) && $stable(uop_src_o) &&
       $stable(uop_imm_o) && $stable(uop_last_o) && $stable(uop_psr_mask_o)));

  p_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o |-> !req_ready_o);

  p_last_ends_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uop_valid_o && uop_ready_i && uop_last_o) |=> !uop_valid_o);
endmodule

// File: tb/lsm_uop_seq_tb.sv
`timescale 1ns/1ps
module lsm_uop_seq_tb;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        req_valid_i, req_ready_o;
  logic [15:0] reg_list_i;
  logic [3:0]  base_idx_i;
  logic        up_i, pre_i, wb_i, load_i, user_i;
  logic        uop_valid_o, uop_ready_i;
  logic [2:0]  uop_kind_o;
  logic [4:0]  uop_dst_o, uop_src_o;
  logic [7:0]  uop_imm_o;
  logic        uop_neg_o, uop_user_o, uop_last_o;
  logic [3:0]  uop_psr_mask_o;

  always #2.5 clk = ~clk;

  lsm_uop_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .reg_list_i(reg_list_i), .base_idx_i(base_idx_i), .up_i(up_i), .pre_i(pre_i),
    .wb_i(wb_i), .load_i(load_i), .user_i(user_i), .uop_valid_o(uop_valid_o),
    .uop_ready_i(uop_ready_i), .uop_kind_o(uop_kind_o), .uop_dst_o(uop_dst_o),
    .uop_src_o(uop_src_o), .uop_imm_o(uop_imm_o), .uop_neg_o(uop_neg_o),
    .uop_user_o(uop_user_o), .uop_psr_mask_o(uop_psr_mask_o), .uop_last_o(uop_last_o)
  );

  // {list, base, up, pre, wb, load, user, stall}
  localparam logic [25:0] VEC [8] = '{
    {16'h00F3, 4'd2,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {16'h8421, 4'd13, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    {16'h8003, 4'd0,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {16'hFFFF, 4'd5,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    {16'h0000, 4'd7,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {16'h0000, 4'd3,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    {16'h8000, 4'd1,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {16'h0100, 4'd4,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1}
  };

  int n_chk = 0, n_fail = 0;
  logic [27:0] exp_q [18];
  int          exp_n;

  task automatic chk(input bit ok, input string req, input logic [27:0] got, input logic [27:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [27:0] cur_uop();
    return {uop_kind_o, uop_dst_o, uop_src_o, uop_imm_o, uop_neg_o, uop_user_o,
            uop_psr_mask_o, uop_last_o};
  endfunction

  // expected stream: R1 copy, R2-R6 transfers, R7 base update, R8 last flag
  task automatic build_exp(input logic [15:0] lst, input logic [3:0] b,
                           input bit up, pre, wb, ld, usr);
    int n = $countones(lst);
    logic [7:0] ofs = up ? 8'd0 : 8'(n * 4 - 4);
    if (pre) ofs = ofs + 8'd4;
    exp_n = 0;
    exp_q[exp_n++] = {3'd0, 5'd16, {1'b0, b}, 8'd0, 1'b0, 1'b0, 4'h0, 1'b0};
    for (int r = 0; r < 16; r++) begin
      if (lst[r]) begin
        bit ret = ld && usr && (r == 15);
        logic [2:0] k = !ld ? 3'd3 : (ret ? 3'd4 : 3'd2);
        exp_q[exp_n++] = {k, 5'(r), 5'd16, ofs, !up, usr, ret ? 4'hF : 4'h0, 1'b0};
        ofs = up ? ofs + 8'd4 : ofs - 8'd4;
      end
    end
    if (wb) exp_q[exp_n++] = {up ? 3'd0 : 3'd1, {1'b0, b}, {1'b0, b}, 8'(n * 4),
                              1'b0, 1'b0, 4'h0, 1'b0};
    exp_q[exp_n-1][0] = 1'b1;
  endtask

  task automatic run_seq(input logic [25:0] v);
    logic [27:0] held = '0;
    bit stalled = 0, stall = v[0];
    int idx = 0, cyc = 0;
    build_exp(v[25:10], v[9:6], v[5], v[4], v[3], v[2], v[1]);
    @(negedge clk);
    chk(req_ready_o && !uop_valid_o, "R11 idle before request", {27'd0, req_ready_o}, 28'd1);
    req_valid_i = 1'b1; reg_list_i = v[25:10]; base_idx_i = v[9:6];
    up_i = v[5]; pre_i = v[4]; wb_i = v[3]; load_i = v[2]; user_i = v[1];
    @(negedge clk);
    // request ignored while busy (R11)
    reg_list_i = 16'hAAAA; base_idx_i = 4'd9; up_i = ~v[5]; wb_i = ~v[3];
    while (idx < exp_n && cyc < 200) begin
      uop_ready_i = stall ? ((cyc % 3) != 1) : 1'b1;
      if (stalled) chk(cur_uop() == held, "R10 hold", cur_uop(), held);
      if (!uop_valid_o) chk(1'b0, "R8 stream ended early", 28'd0, exp_q[idx]);
      else if (uop_ready_i) begin
        if (idx == 0) chk(cur_uop() == exp_q[idx], "R1 copy", cur_uop(), exp_q[idx]);
        else if (v[3] && idx == exp_n - 1)
          chk(cur_uop() == exp_q[idx], "R7 base update", cur_uop(), exp_q[idx]);
        else chk(cur_uop() == exp_q[idx], "R2 R3 R4 R5 R6 transfer", cur_uop(), exp_q[idx]);
        chk(!req_ready_o, "R11 busy", {27'd0, req_ready_o}, 28'd0);
        idx++;
        stalled = 0;
        if (idx == exp_n) req_valid_i = 1'b0;
      end else begin
        held = cur_uop();
        stalled = 1;
      end
      cyc++;
      @(negedge clk);
    end
    req_valid_i = 1'b0;
    chk(!uop_valid_o && req_ready_o, "R8 R9 no extra uop, ready again",
        {26'd0, uop_valid_o, req_ready_o}, 28'd1);
  endtask

  initial begin
    rst_ni = 1'b0; req_valid_i = 1'b0; uop_ready_i = 1'b0; reg_list_i = '0;
    base_idx_i = '0; up_i = 0; pre_i = 0; wb_i = 0; load_i = 0; user_i = 0;
    #1;
    chk(!uop_valid_o && req_ready_o, "R12 in reset", {26'd0, uop_valid_o, req_ready_o}, 28'd1);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!uop_valid_o && req_ready_o, "R12 after reset", {26'd0, uop_valid_o, req_ready_o}, 28'd1);

    for (int i = 0; i < 8; i++) run_seq(VEC[i]);

    // reset in the middle of a sequence
    req_valid_i = 1'b1; reg_list_i = 16'h0FF0; uop_ready_i = 1'b0;
    @(negedge clk);
    req_valid_i = 1'b0;
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk(!uop_valid_o && req_ready_o, "R12 mid-sequence reset", {26'd0, uop_valid_o, req_ready_o}, 28'd1);
    @(negedge clk);
    rst_ni = 1'b1;
    run_seq(VEC[2]);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule